// File: doc/BRIEF.md
# Wish Branch Fetch Steering and Recovery Controller

This front-end control unit handles the three wish branch kinds: jump, join and loop. When a wish branch is fetched, the unit receives its kind, the predicted direction and a one-bit confidence flag. From these it picks the direction that fetch follows and whether the branch runs as normal branch code or in predicated mode. That choice is held in a small table, indexed by a tag the controller hands out in program order.

When a branch resolves, the unit reads back the mode that was used at fetch time and compares the real outcome with the path that was fetched. It then does one of two things. It either raises a one-cycle flush pulse that carries the redirect PC, or it signals that the extra predicated instructions retire as no-ops. A flush also discards every younger table entry and rewinds tag allocation to just past the branch that flushed.

The fetch side uses a valid/ready handshake. `fet_ready` is low when the tag table is full, and also in any cycle where a resolution triggers a flush. In both cases the offered branch is not taken, and upstream must hold it, or drop it after the redirect. Resolution is a plain strobe with no back-pressure. A resolve for a tag that is not in flight is ignored. DEPTH must be a power of two.

Top module: `wish_branch_ctrl`

## Requirements
- R1: With `fet_conf_high`=1, `fet_go_taken` equals `fet_pred_taken` and `fet_predicated`=0, whatever the kind (kind codes: 0 jump, 1 join, 2 loop).
- R2: With low confidence, a jump (0) or join (1) is fetched not-taken (`fet_go_taken`=0) with `fet_predicated`=1.
- R3: With low confidence, a loop (2) follows its prediction with `fet_predicated`=1. For a loop, taken means another iteration.
- R4: A predicated jump or join never flushes. Its resolution raises `nop_retire_o` for one cycle, one cycle after the resolve strobe.
- R5: Early exit: if a predicated loop was fetched as exiting but actually continues, the result is a flush to `res_taken_pc`.
- R6: Late exit: if a predicated loop was fetched as continuing, actually exits, and `res_exit_fetched`=1, there is no flush and `nop_retire_o` pulses.
- R7: No exit: the same case as R6 but with `res_exit_fetched`=0 gives a flush to `res_fall_pc`.
- R8: For a branch fetched in normal mode, a misprediction flushes to the PC of the actual direction. A correct prediction raises neither flush nor no-op.
- R9: Recovery uses the mode latched at fetch time. The confidence presented later does not affect it.
- R10: A flush frees the resolving entry and all younger ones. A later resolve of a freed tag does nothing, and the next allocated tag is the flushing tag plus one.
- R11: `fet_ready` is 0 in a cycle where a resolve causes a flush, and also when all DEPTH tags are in flight.
- R12: After reset: `fet_ready`=1, `fet_tag`=0, `flush_o`=0, `nop_retire_o`=0.
- R13: `flush_o` and `nop_retire_o` are registered single-cycle outputs and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fet_valid | input | 1 | A wish branch is offered at fetch |
| fet_ready | output | 1 | Fetch offer accepted this cycle |
| fet_kind | input | 2 | 0 jump, 1 join, 2 loop |
| fet_pred_taken | input | 1 | Predicted direction |
| fet_conf_high | input | 1 | Confidence estimate is high |
| fet_tag | output | TAG_W | Tag assigned to the offered branch |
| fet_go_taken | output | 1 | Direction fetch must follow |
| fet_predicated | output | 1 | Branch is handled in predicated mode |
| res_valid | input | 1 | Resolution strobe |
| res_tag | input | TAG_W | Tag of the resolving branch |
| res_taken | input | 1 | Actual direction |
| res_exit_fetched | input | 1 | Fetched path already reached the loop exit |
| res_taken_pc | input | PC_W | Target PC (loop body for loops) |
| res_fall_pc | input | PC_W | Fall-through PC (loop exit for loops) |
| flush_o | output | 1 | Flush pulse |
| flush_pc_o | output | PC_W | Redirect PC, valid with flush_o |
| nop_retire_o | output | 1 | Predicated wrong-path work retires as no-ops |

## Verification
Each of the three kinds is fetched under both confidence levels, and the steering outputs are compared. This separates the normal-mode rule from the two predicated rules. Predicated loops are resolved under all three mismatch shapes: early, late and no exit. Each shape must give a different response, either a flush to the body, a no-op retire, or a flush to the exit. Normal-mode branches are resolved both hit and miss. A burst of three fetches followed by a flush from the oldest one shows that younger tags are discarded. A resolve that coincides with a fetch offer, and a completely full table, test the refusal rules.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    WB_JUMP = 2'd0,
    WB_JOIN = 2'd1,
    WB_LOOP = 2'd2
  } wb_kind_e;

  typedef struct packed {
    wb_kind_e kind;
    logic     predicated;
    logic     dir;
  } wb_entry_t;
endpackage

// File: rtl/wbc_steer.sv
module wbc_steer
  import wbc_pkg::*;
(
  input  wb_kind_e kind,
  input  logic     pred_taken,
  input  logic     conf_high,
  output logic     go_taken,
  output logic     predicated
);
  always_comb begin
    predicated = !conf_high;
    if (conf_high || kind == WB_LOOP) go_taken = pred_taken;
    else                              go_taken = 1'b0;
  end
endmodule

// File: rtl/wbc_mode_table.sv
module wbc_mode_table
  import wbc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  wb_entry_t        alloc_entry,
  output logic [TAG_W-1:0] head_o,
  output logic             full_o,
  input  logic [TAG_W-1:0] rd_tag,
  output wb_entry_t        rd_entry,
  output logic             rd_valid,
  input  logic             free_en,
  input  logic             flush_en
);
  logic [DEPTH-1:0] vld;
  wb_entry_t        ent [DEPTH];
  logic [TAG_W-1:0] head;
  logic [DEPTH-1:0] younger;
  logic [TAG_W-1:0] dist_head;

  assign dist_head = head - rd_tag;

  for (genvar i = 0; i < DEPTH; i++) begin : g_age
    logic [TAG_W-1:0] dist_i;
    assign dist_i     = TAG_W'(i) - rd_tag;
    assign younger[i] = (dist_i != '0) && ((dist_head == '0) || (dist_i < dist_head));
  end

  assign head_o   = head;
  assign full_o   = vld[head];
  assign rd_entry = ent[rd_tag];
  assign rd_valid = vld[rd_tag];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      head <= '0;
    end else if (flush_en) begin
      for (int i = 0; i < DEPTH; i++)
        if (younger[i] || TAG_W'(i) == rd_tag) vld[i] <= 1'b0;
      head <= rd_tag + 1'b1;
    end else begin
      if (free_en) vld[rd_tag] <= 1'b0;
      if (alloc_en) begin
        vld[head] <= 1'b1;
        head      <= head + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) ent[head] <= alloc_entry;
  end
endmodule

// File: rtl/wbc_resolve.sv
module wbc_resolve
  import wbc_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            hit,
  input  wb_entry_t       entry,
  input  logic            actual_taken,
  input  logic            exit_fetched,
  input  logic [PC_W-1:0] taken_pc,
  input  logic [PC_W-1:0] fall_pc,
  output logic            flush_now,
  output logic [PC_W-1:0] redirect_pc,
  output logic            nop_now
);
  logic fl, np;

  always_comb begin
    fl          = 1'b0;
    np          = 1'b0;
    redirect_pc = fall_pc;
    if (!entry.predicated) begin
      if (actual_taken != entry.dir) begin
        fl          = 1'b1;
        redirect_pc = actual_taken ? taken_pc : fall_pc;
      end
    end else if (entry.kind != WB_LOOP) begin
      np = 1'b1;
    end else if (!entry.dir && actual_taken) begin
      fl          = 1'b1;
      redirect_pc = taken_pc;
    end else if (entry.dir && !actual_taken) begin
      if (exit_fetched) np = 1'b1;
      else              fl = 1'b1;
    end
  end

  assign flush_now = hit && fl;
  assign nop_now   = hit && np;
endmodule

// File: rtl/wish_branch_ctrl.sv
module wish_branch_ctrl
  import wbc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PC_W  = 16,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fet_valid,
  output logic             fet_ready,
  input  logic [1:0]       fet_kind,
  input  logic             fet_pred_taken,
  input  logic             fet_conf_high,
  output logic [TAG_W-1:0] fet_tag,
  output logic             fet_go_taken,
  output logic             fet_predicated,
  input  logic             res_valid,
  input  logic [TAG_W-1:0] res_tag,
  input  logic             res_taken,
  input  logic             res_exit_fetched,
  input  logic [PC_W-1:0]  res_taken_pc,
  input  logic [PC_W-1:0]  res_fall_pc,
  output logic             flush_o,
  output logic [PC_W-1:0]  flush_pc_o,
  output logic             nop_retire_o
);
  wb_kind_e        kind;
  wb_entry_t       new_entry, rd_entry;
  logic            full, rd_valid, hit;
  logic            flush_now, nop_now;
  logic [PC_W-1:0] redirect_pc;

  assign kind = wb_kind_e'(fet_kind);

  wbc_steer u_steer (
    .kind       (kind),
    .pred_taken (fet_pred_taken),
    .conf_high  (fet_conf_high),
    .go_taken   (fet_go_taken),
    .predicated (fet_predicated)
  );

  assign new_entry = '{kind: kind, predicated: fet_predicated, dir: fet_go_taken};
  assign hit       = res_valid && rd_valid;
  assign fet_ready = !full && !flush_now;

  wbc_mode_table #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_en    (fet_valid && fet_ready),
    .alloc_entry (new_entry),
    .head_o      (fet_tag),
    .full_o      (full),
    .rd_tag      (res_tag),
    .rd_entry    (rd_entry),
    .rd_valid    (rd_valid),
    .free_en     (hit && !flush_now),
    .flush_en    (flush_now)
  );

  wbc_resolve #(.PC_W(PC_W)) u_resolve (
    .hit          (hit),
    .entry        (rd_entry),
    .actual_taken (res_taken),
    .exit_fetched (res_exit_fetched),
    .taken_pc     (res_taken_pc),
    .fall_pc      (res_fall_pc),
    .flush_now    (flush_now),
    .redirect_pc  (redirect_pc),
    .nop_now      (nop_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_o      <= 1'b0;
      flush_pc_o   <= '0;
      nop_retire_o <= 1'b0;
    end else begin
      flush_o      <= flush_now;
      flush_pc_o   <= redirect_pc;
      nop_retire_o <= nop_now;
    end
  end
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fet_valid,
  input logic             fet_ready,
  input logic [1:0]       fet_kind,
  input logic             fet_pred_taken,
  input logic             fet_conf_high,
  input logic [TAG_W-1:0] fet_tag,
  input logic             fet_go_taken,
  input logic             fet_predicated,
  input logic             res_valid,
  input logic [TAG_W-1:0] res_tag,
  input logic             flush_o,
  input logic             nop_retire_o
);
  assert_high_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fet_valid && fet_conf_high) |-> (fet_go_taken == fet_pred_taken && !fet_predicated));

  assert_low_jj_nt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fet_valid && !fet_conf_high && fet_kind != 2'd2) |-> (!fet_go_taken && fet_predicated));

  assert_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush_o && nop_retire_o));

  assert_flush_needs_res_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> $past(res_valid));

  assert_rewind_tag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (fet_tag == TAG_W'($past(res_tag) + 1'b1)));

  assert_accept_no_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fet_valid && fet_ready) |=> !flush_o);
endmodule

bind wish_branch_ctrl wbc_checker #(.TAG_W(TAG_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fet_valid      (fet_valid),
  .fet_ready      (fet_ready),
  .fet_kind       (fet_kind),
  .fet_pred_taken (fet_pred_taken),
  .fet_conf_high  (fet_conf_high),
  .fet_tag        (fet_tag),
  .fet_go_taken   (fet_go_taken),
  .fet_predicated (fet_predicated),
  .res_valid      (res_valid),
  .res_tag        (res_tag),
  .flush_o        (flush_o),
  .nop_retire_o   (nop_retire_o)
);

// File: tb/tb_wish_branch_ctrl.sv
module tb_wish_branch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int PC_W  = 16;
  localparam int TAG_W = 3;
  localparam logic [PC_W-1:0] TPC = 16'h1200;
  localparam logic [PC_W-1:0] FPC = 16'h3400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fet_valid = 1'b0, fet_pred_taken = 1'b0, fet_conf_high = 1'b0;
  logic [1:0] fet_kind = 2'd0;
  logic fet_ready, fet_go_taken, fet_predicated;
  logic [TAG_W-1:0] fet_tag;
  logic res_valid = 1'b0, res_taken = 1'b0, res_exit_fetched = 1'b0;
  logic [TAG_W-1:0] res_tag = '0;
  logic [PC_W-1:0] res_taken_pc = TPC, res_fall_pc = FPC;
  logic flush_o, nop_retire_o;
  logic [PC_W-1:0] flush_pc_o;
  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wish_branch_ctrl #(.DEPTH(DEPTH), .PC_W(PC_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .fet_valid(fet_valid), .fet_ready(fet_ready), .fet_kind(fet_kind),
    .fet_pred_taken(fet_pred_taken), .fet_conf_high(fet_conf_high),
    .fet_tag(fet_tag), .fet_go_taken(fet_go_taken), .fet_predicated(fet_predicated),
    .res_valid(res_valid), .res_tag(res_tag), .res_taken(res_taken),
    .res_exit_fetched(res_exit_fetched), .res_taken_pc(res_taken_pc),
    .res_fall_pc(res_fall_pc), .flush_o(flush_o), .flush_pc_o(flush_pc_o),
    .nop_retire_o(nop_retire_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [1:0] kind, input logic pred, input logic conf,
                          input logic exp_go, input logic exp_pm, input int exp_tag, input string req);
    @(negedge clk);
    fet_valid = 1'b1; fet_kind = kind; fet_pred_taken = pred; fet_conf_high = conf;
    #1;
    chk({req, " ready"}, 32'(fet_ready), 32'd1);
    chk({req, " tag"}, 32'(fet_tag), 32'(exp_tag));
    chk({req, " dir"}, 32'(fet_go_taken), 32'(exp_go));
    chk({req, " mode"}, 32'(fet_predicated), 32'(exp_pm));
    @(posedge clk); #1;
    fet_valid = 1'b0;
  endtask

  task automatic do_res(input int tag, input logic act, input logic exitf,
                        input logic exp_fl, input logic [PC_W-1:0] exp_pc, input logic exp_nop, input string req);
    @(negedge clk);
    res_valid = 1'b1; res_tag = TAG_W'(tag); res_taken = act; res_exit_fetched = exitf;
    @(posedge clk); #1;
    res_valid = 1'b0;
    chk({req, " flush"}, 32'(flush_o), 32'(exp_fl));
    chk({req, " nop"}, 32'(nop_retire_o), 32'(exp_nop));
    if (exp_fl) chk({req, " pc"}, 32'(flush_pc_o), 32'(exp_pc));
  endtask

  task automatic t_reset();
    #1;
    chk("R12 ready", 32'(fet_ready), 32'd1);
    chk("R12 tag", 32'(fet_tag), 32'd0);
    chk("R12 flush", 32'(flush_o), 32'd0);
    chk("R12 nop", 32'(nop_retire_o), 32'd0);
  endtask

  task automatic t_normal();
    do_fetch(2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 0, "R1 jump hi");
    do_res(0, 1'b0, 1'b0, 1'b1, FPC, 1'b0, "R8 miss");
    do_fetch(2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1, "R1 loop hi");
    do_res(1, 1'b1, 1'b0, 1'b0, FPC, 1'b0, "R8 hit");
  endtask

  task automatic t_low_jj();
    do_fetch(2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 2, "R2 jump lo");
    do_fetch(2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 3, "R2 join lo");
    do_res(2, 1'b1, 1'b0, 1'b0, FPC, 1'b1, "R4 jump");
    do_res(3, 1'b0, 1'b0, 1'b0, FPC, 1'b1, "R4 join");
  endtask

  task automatic t_loops();
    do_fetch(2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 4, "R3 loop lo exit");
    do_res(4, 1'b1, 1'b0, 1'b1, TPC, 1'b0, "R5 early");
    do_fetch(2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 5, "R3 loop lo cont");
    do_res(5, 1'b0, 1'b1, 1'b0, FPC, 1'b1, "R6 late");
    do_fetch(2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 6, "R3 loop lo cont2");
    do_res(6, 1'b0, 1'b0, 1'b1, FPC, 1'b0, "R7 noexit");
  endtask

  task automatic t_mode_latched();
    do_fetch(2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 7, "R9 fetch");
    fet_conf_high = 1'b0;
    do_res(7, 1'b0, 1'b0, 1'b1, FPC, 1'b0, "R9 normal-mode flush");
  endtask

  task automatic t_younger();
    do_fetch(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 0, "R10 a");
    do_fetch(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1, "R10 b");
    do_fetch(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 2, "R10 c");
    do_res(0, 1'b1, 1'b0, 1'b1, TPC, 1'b0, "R10 flush oldest");
    do_res(2, 1'b1, 1'b0, 1'b0, FPC, 1'b0, "R10 stale ignored");
    do_fetch(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1, "R10 refetch tag");
    do_res(1, 1'b0, 1'b0, 1'b0, FPC, 1'b0, "R10 refetch hit");
  endtask

  task automatic t_priority();
    do_fetch(2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 2, "R11 setup");
    @(negedge clk);
    res_valid = 1'b1; res_tag = 3'd2; res_taken = 1'b0; res_exit_fetched = 1'b0;
    fet_valid = 1'b1; fet_kind = 2'd0; fet_conf_high = 1'b1;
    #1;
    chk("R11 ready low on flush", 32'(fet_ready), 32'd0);
    @(posedge clk); #1;
    res_valid = 1'b0; fet_valid = 1'b0;
    chk("R11 flush", 32'(flush_o), 32'd1);
    chk("R11 pc", 32'(flush_pc_o), 32'(FPC));
    do_fetch(2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 3, "R11 after flush");
    do_res(3, 1'b1, 1'b0, 1'b0, FPC, 1'b0, "R11 cleanup");
  endtask

  task automatic t_full();
    for (int k = 0; k < DEPTH; k++)
      do_fetch(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, (4 + k) % DEPTH, "R11 fill");
    @(negedge clk); #1;
    chk("R11 full ready", 32'(fet_ready), 32'd0);
    do_res(4, 1'b0, 1'b0, 1'b0, FPC, 1'b0, "R11 free one");
    @(negedge clk); #1;
    chk("R11 ready again", 32'(fet_ready), 32'd1);
    chk("R11 free tag", 32'(fet_tag), 32'd4);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_normal();
    t_low_jj();
    t_loops();
    t_mode_latched();
    t_younger();
    t_priority();
    t_full();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule